// File: doc/BRIEF.md
# Serial Command Decoder with Auto-Incrementing Addresses

This block takes a write-only, three-wire serial link from a host controller (an active-low select, a shift clock and a data line) and turns it into write strobes for a character display engine. All three wires are brought into the system clock domain through synchronizer flops. The bus is sampled on rising edges of the shift clock, least significant bit first. Each group of eight bits forms one byte, and the byte count starts again whenever select falls.

The first byte of a command carries an opcode in bits 7:5. Three opcodes open a streaming mode:

- The character-code mode drives a 5-bit address.
- The symbol mode drives a 5-bit address and stores only a nibble per byte.
- The pattern mode drives a 4-bit entry address and fills five 7-bit columns per entry.

In a streaming mode, every later byte in the same select window is data for the next address. The other opcodes load small registers held in the block: the output port, the brightness level (two bytes), the active digit count and the lamp override.

The controller is a five-state machine:

- `ST_CMD` waits for a command byte.
- `ST_CODE`, `ST_PAT` and `ST_SYM` stream data.
- `ST_BRT` waits for the high brightness byte.

Its transitions are as follows:

- A command byte moves `ST_CMD` to the matching streaming state or to `ST_BRT`.
- A single-byte command, or the test opcode, keeps the machine in `ST_CMD`.
- The second brightness byte returns `ST_BRT` to `ST_CMD`.
- Streaming states loop on themselves for each byte.
- Select going high forces every state back to `ST_CMD`.

Top module: `serial_cmd_decoder`

## Requirements
- R1: After reset, `port_out`, `bright_lvl`, `digit_cnt` and `lamp_ovr` are all zero and no write strobe is pulsed.
- R2: A byte is assembled from 8 rising shift-clock edges while `sel_n` is low, first bit into bit 0. Bits of an unfinished byte are dropped when `sel_n` rises, and each falling edge of `sel_n` starts a new byte.
- R3: The opcode is the first byte's bits 7:5 read as a number: 1 character code, 2 pattern, 3 symbol, 4 output port, 5 brightness, 6 digit count, 7 lamp override.
- R4: The character-code command loads a pointer from bits 4:0. Each following byte is written at the pointer, which then increments. Pointer values 24 to 31 produce no strobe, and 31 wraps to 0.
- R5: The pattern command loads an entry pointer from bits 3:0. Following bytes supply columns 0 to 4 of that entry from bits 6:0. After column 4 the entry increments, with 15 wrapping to 0.
- R6: The symbol command follows the addressing of R4 on its own pointer and stores only bits 3:0 of each data byte.
- R7: Brightness is `{second byte, first byte bits 1:0}`. If `sel_n` rises before the second byte arrives, `bright_lvl` is left unchanged.
- R8: The output port command loads bits 3:0 of its byte into `port_out`, the digit-count command loads bits 3:0 into `digit_cnt`, and the lamp-override command loads bits 1:0 into `lamp_ovr`. The other bits of these bytes are ignored.
- R9: In a streaming mode, every byte counts as data until `sel_n` goes high, even if it looks like a command. After a single-byte or brightness command, another command may follow in the same select window.
- R10: At most one of the three RAM strobes is high in any cycle, and each strobe lasts a single cycle.
- R11: A first byte with opcode 0 changes nothing and leaves the decoder waiting for a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial shift clock, asynchronous |
| sdat | input | 1 | Serial data, asynchronous |
| code_we | output | 1 | Character-code RAM write strobe |
| code_addr | output | 5 | Character-code RAM address |
| code_data | output | 8 | Character code |
| pat_we | output | 1 | Pattern RAM column write strobe |
| pat_addr | output | 4 | Pattern entry address |
| pat_col | output | 3 | Column index 0 to 4 |
| pat_data | output | 7 | Column dots |
| sym_we | output | 1 | Symbol RAM write strobe |
| sym_addr | output | 5 | Symbol RAM address |
| sym_data | output | 4 | Symbol bits |
| port_out | output | 4 | Output port register |
| bright_lvl | output | 10 | Brightness register |
| digit_cnt | output | 4 | Digit-count register |
| lamp_ovr | output | 2 | Lamp-override register |

## Verification
The character-code stream starts at address 0 and runs for 33 bytes. This shows whether the pointer increments, skips the eight unused addresses and wraps to rewrite address 0. A second stream starts at 22 with a command-like byte inside it, which shows a streaming mode being confused with command mode.

Patterns start at entry 15 across ten bytes with bit 7 set, which exercises column order, entry wrap and field masking. Symbols start at 30, which shows discarding and nibble masking. Every value of the port and digit-count registers and of the override field is swept with junk in the ignored bits. This exposes bit-order and field-position faults.

Brightness is tried at its extreme and alternating values. Aborted frames, partial bytes, opcode 0 and several commands in one frame separate correct framing from misaligned byte counting.

// File: rtl/scd_pkg.sv
package scd_pkg;

    localparam int BYTE_W  = 8;
    localparam int OPC_LSB = 5;

    typedef enum logic [2:0] {
        OP_TEST = 3'd0,
        OP_CODE = 3'd1,
        OP_PAT  = 3'd2,
        OP_SYM  = 3'd3,
        OP_PORT = 3'd4,
        OP_BRT  = 3'd5,
        OP_DIG  = 3'd6,
        OP_OVR  = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_CODE,
        ST_PAT,
        ST_SYM,
        ST_BRT
    } state_e;

endpackage

// File: rtl/scd_sync.sv
module scd_sync #(
    parameter int                W       = 3,
    parameter int                STAGES  = 2,
    parameter logic [W-1:0]      RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/scd_byte_rx.sv
module scd_byte_rx
    import scd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdat,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_q
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_d;
    logic [BYTE_W-2:0] shreg;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            shreg    <= '0;
            cnt      <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else begin
            byte_vld <= 1'b0;
            sclk_d   <= sclk;
            if (sel_n) begin
                cnt <= '0;
            end else if (sclk && !sclk_d) begin
                shreg <= {sdat, shreg[BYTE_W-2:1]};
                cnt   <= cnt + 1'b1;
                if (cnt == CNT_W'(BYTE_W - 1)) begin
                    byte_vld <= 1'b1;
                    byte_q   <= {sdat, shreg};
                end
            end
        end
    end
endmodule

// File: rtl/scd_ctrl.sv
module scd_ctrl
    import scd_pkg::*;
#(
    parameter int CODE_AW    = 5,
    parameter int CODE_DEPTH = 24,
    parameter int PAT_AW     = 4,
    parameter int PAT_COLS   = 5,
    parameter int COL_W      = 7,
    parameter int SYM_W      = 4,
    parameter int PORT_W     = 4,
    parameter int DIG_W      = 4,
    parameter int OVR_W      = 2,
    parameter int BRT_LO_W   = 2,
    localparam int COL_IW    = $clog2(PAT_COLS),
    localparam int BRT_W     = BYTE_W + BRT_LO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_n,
    input  logic               byte_vld,
    input  logic [BYTE_W-1:0]  byte_in,
    output logic               code_we,
    output logic [CODE_AW-1:0] code_addr,
    output logic [BYTE_W-1:0]  code_data,
    output logic               pat_we,
    output logic [PAT_AW-1:0]  pat_addr,
    output logic [COL_IW-1:0]  pat_col,
    output logic [COL_W-1:0]   pat_data,
    output logic               sym_we,
    output logic [CODE_AW-1:0] sym_addr,
    output logic [SYM_W-1:0]   sym_data,
    output logic [PORT_W-1:0]  port_out,
    output logic [BRT_W-1:0]   bright_lvl,
    output logic [DIG_W-1:0]   digit_cnt,
    output logic [OVR_W-1:0]   lamp_ovr
);
    state_e              state_q, state_d;
    opcode_e             opc;
    logic [CODE_AW-1:0]  code_ptr, sym_ptr;
    logic [PAT_AW-1:0]   pat_ptr;
    logic [COL_IW-1:0]   col_ptr;
    logic [BRT_LO_W-1:0] brt_lo;
    logic                take;

    assign opc  = opcode_e'(byte_in[BYTE_W-1:OPC_LSB]);
    assign take = byte_vld && !sel_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CMD;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (sel_n) begin
            state_d = ST_CMD;
        end else if (byte_vld) begin
            unique case (state_q)
                ST_CMD: begin
                    unique case (opc)
                        OP_CODE: state_d = ST_CODE;
                        OP_PAT:  state_d = ST_PAT;
                        OP_SYM:  state_d = ST_SYM;
                        OP_BRT:  state_d = ST_BRT;
                        default: state_d = ST_CMD;
                    endcase
                end
                ST_BRT:  state_d = ST_CMD;
                ST_CODE: state_d = ST_CODE;
                ST_PAT:  state_d = ST_PAT;
                ST_SYM:  state_d = ST_SYM;
                default: state_d = ST_CMD;
            endcase
        end
    end

    // outputs, pointers and registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_we    <= 1'b0;
            code_addr  <= '0;
            code_data  <= '0;
            pat_we     <= 1'b0;
            pat_addr   <= '0;
            pat_col    <= '0;
            pat_data   <= '0;
            sym_we     <= 1'b0;
            sym_addr   <= '0;
            sym_data   <= '0;
            port_out   <= '0;
            bright_lvl <= '0;
            digit_cnt  <= '0;
            lamp_ovr   <= '0;
            code_ptr   <= '0;
            sym_ptr    <= '0;
            pat_ptr    <= '0;
            col_ptr    <= '0;
            brt_lo     <= '0;
        end else begin
            code_we <= 1'b0;
            pat_we  <= 1'b0;
            sym_we  <= 1'b0;
            if (take) begin
                unique case (state_q)
                    ST_CMD: begin
                        unique case (opc)
                            OP_CODE: code_ptr  <= byte_in[CODE_AW-1:0];
                            OP_SYM:  sym_ptr   <= byte_in[CODE_AW-1:0];
                            OP_PAT: begin
                                pat_ptr <= byte_in[PAT_AW-1:0];
                                col_ptr <= '0;
                            end
                            OP_BRT:  brt_lo    <= byte_in[BRT_LO_W-1:0];
                            OP_PORT: port_out  <= byte_in[PORT_W-1:0];
                            OP_DIG:  digit_cnt <= byte_in[DIG_W-1:0];
                            OP_OVR:  lamp_ovr  <= byte_in[OVR_W-1:0];
                            default: ;
                        endcase
                    end
                    ST_CODE: begin
                        code_we   <= (code_ptr < CODE_AW'(CODE_DEPTH));
                        code_addr <= code_ptr;
                        code_data <= byte_in;
                        code_ptr  <= code_ptr + 1'b1;
                    end
                    ST_SYM: begin
                        sym_we   <= (sym_ptr < CODE_AW'(CODE_DEPTH));
                        sym_addr <= sym_ptr;
                        sym_data <= byte_in[SYM_W-1:0];
                        sym_ptr  <= sym_ptr + 1'b1;
                    end
                    ST_PAT: begin
                        pat_we   <= 1'b1;
                        pat_addr <= pat_ptr;
                        pat_col  <= col_ptr;
                        pat_data <= byte_in[COL_W-1:0];
                        if (col_ptr == COL_IW'(PAT_COLS - 1)) begin
                            col_ptr <= '0;
                            pat_ptr <= pat_ptr + 1'b1;
                        end else begin
                            col_ptr <= col_ptr + 1'b1;
                        end
                    end
                    ST_BRT:  bright_lvl <= {byte_in, brt_lo};
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
    import scd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CODE_AW     = 5,
    parameter int CODE_DEPTH  = 24,
    parameter int PAT_AW      = 4,
    parameter int PAT_COLS    = 5,
    parameter int COL_W       = 7,
    parameter int SYM_W       = 4,
    parameter int PORT_W      = 4,
    parameter int DIG_W       = 4,
    parameter int OVR_W       = 2,
    localparam int COL_IW     = $clog2(PAT_COLS),
    localparam int BRT_W      = BYTE_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_n,
    input  logic               sclk,
    input  logic               sdat,
    output logic               code_we,
    output logic [CODE_AW-1:0] code_addr,
    output logic [BYTE_W-1:0]  code_data,
    output logic               pat_we,
    output logic [PAT_AW-1:0]  pat_addr,
    output logic [COL_IW-1:0]  pat_col,
    output logic [COL_W-1:0]   pat_data,
    output logic               sym_we,
    output logic [CODE_AW-1:0] sym_addr,
    output logic [SYM_W-1:0]   sym_data,
    output logic [PORT_W-1:0]  port_out,
    output logic [BRT_W-1:0]   bright_lvl,
    output logic [DIG_W-1:0]   digit_cnt,
    output logic [OVR_W-1:0]   lamp_ovr
);
    logic [2:0]        bus_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_q;

    scd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sel_n, sclk, sdat}),
        .dout (bus_s)
    );

    scd_byte_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (bus_s[2]),
        .sclk    (bus_s[1]),
        .sdat    (bus_s[0]),
        .byte_vld(byte_vld),
        .byte_q  (byte_q)
    );

    scd_ctrl #(
        .CODE_AW(CODE_AW), .CODE_DEPTH(CODE_DEPTH), .PAT_AW(PAT_AW),
        .PAT_COLS(PAT_COLS), .COL_W(COL_W), .SYM_W(SYM_W),
        .PORT_W(PORT_W), .DIG_W(DIG_W), .OVR_W(OVR_W), .BRT_LO_W(2)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (bus_s[2]),
        .byte_vld  (byte_vld),
        .byte_in   (byte_q),
        .code_we   (code_we),
        .code_addr (code_addr),
        .code_data (code_data),
        .pat_we    (pat_we),
        .pat_addr  (pat_addr),
        .pat_col   (pat_col),
        .pat_data  (pat_data),
        .sym_we    (sym_we),
        .sym_addr  (sym_addr),
        .sym_data  (sym_data),
        .port_out  (port_out),
        .bright_lvl(bright_lvl),
        .digit_cnt (digit_cnt),
        .lamp_ovr  (lamp_ovr)
    );
endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
    parameter int CODE_AW    = 5,
    parameter int CODE_DEPTH = 24,
    parameter int PAT_COLS   = 5,
    localparam int COL_IW    = $clog2(PAT_COLS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               code_we,
    input logic [CODE_AW-1:0] code_addr,
    input logic               pat_we,
    input logic [COL_IW-1:0]  pat_col,
    input logic               sym_we,
    input logic [CODE_AW-1:0] sym_addr
);
    // R10
    one_ram_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({code_we, pat_we, sym_we}));

    // R10
    code_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_we |=> !code_we);

    // R4
    code_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_we |-> (code_addr < CODE_AW'(CODE_DEPTH)));

    // R6
    sym_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_we |-> (sym_addr < CODE_AW'(CODE_DEPTH)));

    // R5
    pat_col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_we |-> (pat_col < COL_IW'(PAT_COLS)));
endmodule

bind serial_cmd_decoder scd_checker #(
    .CODE_AW(CODE_AW), .CODE_DEPTH(CODE_DEPTH), .PAT_COLS(PAT_COLS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_we  (code_we),
    .code_addr(code_addr),
    .pat_we   (pat_we),
    .pat_col  (pat_col),
    .sym_we   (sym_we),
    .sym_addr (sym_addr)
);

// File: tb/tb_serial_cmd_decoder.sv
module tb_serial_cmd_decoder;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1;
    logic sclk = 1'b0;
    logic sdat = 1'b0;

    logic       code_we;  logic [4:0] code_addr; logic [7:0] code_data;
    logic       pat_we;   logic [3:0] pat_addr;  logic [2:0] pat_col;  logic [6:0] pat_data;
    logic       sym_we;   logic [4:0] sym_addr;  logic [3:0] sym_data;
    logic [3:0] port_out; logic [9:0] bright_lvl; logic [3:0] digit_cnt; logic [1:0] lamp_ovr;

    int n_cmp = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdat(sdat),
        .code_we(code_we), .code_addr(code_addr), .code_data(code_data),
        .pat_we(pat_we), .pat_addr(pat_addr), .pat_col(pat_col), .pat_data(pat_data),
        .sym_we(sym_we), .sym_addr(sym_addr), .sym_data(sym_data),
        .port_out(port_out), .bright_lvl(bright_lvl),
        .digit_cnt(digit_cnt), .lamp_ovr(lamp_ovr)
    );

    // write monitors
    logic [7:0] code_mem [32];
    logic [6:0] pat_mem  [16][5];
    logic [3:0] sym_mem  [32];
    int code_wr = 0, pat_wr = 0, sym_wr = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (code_we) begin code_mem[code_addr] = code_data; code_wr++; end
            if (pat_we && pat_col < 5) begin pat_mem[pat_addr][pat_col] = pat_data; pat_wr++; end
            if (sym_we) begin sym_mem[sym_addr] = sym_data; sym_wr++; end
        end
    end

    task automatic chk(input string what, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    endtask

    task automatic wclk(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sdat = b[i];
            wclk(3);
            sclk = 1'b1;
            wclk(4);
            sclk = 1'b0;
            wclk(3);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic frame_open();
        sel_n = 1'b0;
        wclk(4);
    endtask

    task automatic frame_close();
        wclk(4);
        sel_n = 1'b1;
        wclk(8);
    endtask

    function automatic logic [7:0] cd(input int i);
        return 8'((i * 37 + 11) & 8'hFF);
    endfunction

    function automatic logic [7:0] pd(input int i);
        return 8'(8'h80 | ((i * 13 + 5) & 8'h7F));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        wclk(5);
        rst_n = 1'b1;
        wclk(5);

        // R1 reset state
        chk("R1 port_out", int'(port_out), 0);
        chk("R1 bright_lvl", int'(bright_lvl), 0);
        chk("R1 digit_cnt", int'(digit_cnt), 0);
        chk("R1 lamp_ovr", int'(lamp_ovr), 0);
        chk("R1 strobes", code_wr + pat_wr + sym_wr, 0);

        // R4 code stream from 0: 24 writes, 8 discards, wrap rewrites 0
        frame_open();
        send_byte(8'h20);
        for (int i = 0; i < 33; i++) send_byte(cd(i));
        frame_close();
        chk("R4 code write count", code_wr, 25);
        chk("R4 code wrap addr0", int'(code_mem[0]), int'(cd(32)));
        for (int k = 1; k < 24; k++) chk("R4 code data", int'(code_mem[k]), int'(cd(k)));

        // R4/R9 stream from 22 with command-looking byte as data
        code_wr = 0;
        frame_open();
        send_byte(8'h36);
        send_byte(8'h8F);
        send_byte(8'h5A);
        send_byte(8'h11);
        send_byte(8'h22);
        frame_close();
        chk("R4 code count from 22", code_wr, 2);
        chk("R9 command-like byte stored", int'(code_mem[22]), 8'h8F);
        chk("R4 code addr23", int'(code_mem[23]), 8'h5A);
        chk("R9 port untouched in stream", int'(port_out), 0);

        // R5 pattern from entry 15, wraps to 0
        frame_open();
        send_byte(8'h4F);
        for (int i = 0; i < 10; i++) send_byte(pd(i));
        frame_close();
        chk("R5 pattern count", pat_wr, 10);
        for (int c = 0; c < 5; c++) begin
            chk("R5 entry15 column", int'(pat_mem[15][c]), int'(pd(c) & 8'h7F));
            chk("R5 entry0 column", int'(pat_mem[0][c]), int'(pd(5 + c) & 8'h7F));
        end

        // R6 symbol from 30: two discards, then addr 0; nibble only
        frame_open();
        send_byte(8'h7E);
        send_byte(8'hA5);
        send_byte(8'h3C);
        send_byte(8'hF9);
        frame_close();
        chk("R6 symbol count", sym_wr, 1);
        chk("R6 symbol nibble addr0", int'(sym_mem[0]), 9);
        frame_open();
        send_byte(8'h65);
        send_byte(8'hB7);
        frame_close();
        chk("R6 symbol addr5", int'(sym_mem[5]), 7);

        // R8 port / digit / override sweeps with junk in ignored bits
        for (int v = 0; v < 16; v++) begin
            frame_open();
            send_byte(8'(8'h90 | v));
            frame_close();
            chk("R8 port_out", int'(port_out), v);
        end
        for (int v = 0; v < 16; v++) begin
            frame_open();
            send_byte(8'(8'hD0 | v));
            frame_close();
            chk("R8 digit_cnt", int'(digit_cnt), v);
        end
        for (int v = 0; v < 4; v++) begin
            frame_open();
            send_byte(8'(8'hFC | v));
            frame_close();
            chk("R8 lamp_ovr", int'(lamp_ovr), v);
        end

        // R7 brightness values
        begin
            int vals[5] = '{0, 1023, 341, 682, 961};
            for (int j = 0; j < 5; j++) begin
                frame_open();
                send_byte(8'(8'hBC | (vals[j] & 3)));
                send_byte(8'(vals[j] >> 2));
                frame_close();
                chk("R7 bright_lvl", int'(bright_lvl), vals[j]);
            end
        end

        // R7 aborted brightness leaves value
        frame_open();
        send_byte(8'hA1);
        frame_close();
        chk("R7 aborted bright", int'(bright_lvl), 961);

        // R2 partial byte dropped, new frame aligned
        frame_open();
        send_bits(8'hFF, 5);
        frame_close();
        frame_open();
        send_byte(8'hC5);
        frame_close();
        chk("R2 partial dropped digit", int'(digit_cnt), 5);
        chk("R2 LSB-first port", int'(port_out), 15);

        // R9 several commands in one frame
        frame_open();
        send_byte(8'h83);
        send_byte(8'hC9);
        send_byte(8'hE2);
        frame_close();
        chk("R9 port in multi", int'(port_out), 3);
        chk("R9 digit in multi", int'(digit_cnt), 9);
        chk("R9 ovr in multi", int'(lamp_ovr), 2);

        // R11 opcode 0 ignored, next command still decoded
        code_wr = 0; pat_wr = 0; sym_wr = 0;
        frame_open();
        send_byte(8'h0F);
        send_byte(8'h85);
        frame_close();
        chk("R11 no strobes", code_wr + pat_wr + sym_wr, 0);
        chk("R11 then port", int'(port_out), 5);
        chk("R11 digit kept", int'(digit_cnt), 9);

        // R3 each opcode reaches only its own target
        frame_open();
        send_byte(8'h2A);
        send_byte(8'h77);
        frame_close();
        chk("R3 opcode1 code", int'(code_mem[10]), 8'h77);
        chk("R3 opcode1 only code", pat_wr + sym_wr, 0);

        summary();
        $finish;
    end
endmodule